// File: doc/BRIEF.md
# Return-to-Primary Clock Switch Controller

This block owns the system clock of a small core that can run either from its primary oscillator or from one of two secondary sources: a slow timer oscillator or an internal RC oscillator. Software picks the source through a two-bit select field and a timer-oscillator enable. Leaving primary for a secondary source is a plain glitch-free handover. The return to primary is the sequenced path. First, when the primary is a crystal, a start-up count of primary cycles runs while the core keeps executing from the secondary clock. Then the core phase generator is held while the clock multiplexer hands over and a fixed number of primary falling edges is counted. For non-crystal primaries, an extra ready delay follows. Last, the oscillator that is no longer needed is shut down unless something else still uses it.

All sequencing runs in the primary clock domain. The select field and the enable cross into it through two-flop synchronizers. The output clock comes from a three-way multiplexer in which each source's gate enable is set on that source's falling edge, and only while no other gate is open. Reset enters the same hold sequence that a return from secondary uses, so the core starts on primary with the status flag set.

Top module: `clk_return_ctrl`

## Requirements
- R1: After reset the system clock comes from `clk_pri`. `q1_hold` is high until the handover and hold count have finished, then falls, and `ost_done` is 1.
- R2: Select encoding: `clk_sel` = 00 selects primary. 01 selects the timer oscillator, but only while `tmr_osc_on` = 1. Any value with bit 1 set selects the internal RC. On entering secondary, `sys_clk` follows the chosen source, `ost_done` reads 0 and `pri_osc_en` reads 0.
- R3: A return to primary is started either by setting `clk_sel` to 00 or, with `clk_sel` = 01, by clearing `tmr_osc_on`. Clearing the enable behaves as if bit 0 of the select field were 0.
- R4: For `pri_mode` 0, 1 or 2 (crystal modes), `pri_osc_en` is high and `sys_clk` stays on the secondary source while OST_CYC (1024) primary cycles are counted. `q1_hold` rises 1024 to 1030 primary cycles after the request.
- R5: For `pri_mode` 3 (external clock), 4 (external RC) or 5 (internal RC), the start-up count is skipped and `q1_hold` rises within 6 primary cycles of the request.
- R6: `q1_hold` stays high until the primary gate is open and HOLD_EDGES (8) primary falling edges have passed. For modes 3 to 5 it then stays high for a further READY_CYC primary cycles. After `q1_hold` falls, `sys_clk` follows `clk_pri`.
- R7: `ost_done` rises in the same cycle that `q1_hold` falls at the end of a return, and it is 0 at all times while a secondary source is in use.
- R8: After a return from the internal RC, `rc_osc_en` is 0 unless `pri_mode` = 5, `wdt_rc_use` = 1 or `fsm_rc_use` = 1.
- R9: After a return from the timer oscillator, `tmr_osc_en` equals `tmr_osc_on`. During the return it stays 1 even if `tmr_osc_on` was cleared.
- R10: A select change that arrives while a return is in progress is ignored: it neither restarts nor cancels the start-up count.
- R11: At most one source gate is open at any time, so `sys_clk` carries no runt pulse during a handover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary oscillator clock; sequencing domain |
| clk_tmr | input | 1 | Timer oscillator clock (secondary) |
| clk_rc | input | 1 | Internal RC oscillator clock (secondary) |
| rst | input | 1 | Synchronous active-high reset, held across several cycles of every clock |
| clk_sel | input | 2 | Source select field: 00 primary, 01 timer oscillator, 1x internal RC |
| tmr_osc_on | input | 1 | Software enable of the timer oscillator |
| pri_mode | input | 3 | Primary mode: 0 to 2 crystal, 3 external clock, 4 external RC, 5 internal RC |
| wdt_rc_use | input | 1 | Watchdog uses the internal RC |
| fsm_rc_use | input | 1 | Fail-safe monitor uses the internal RC |
| sys_clk | output | 1 | Glitch-free system clock |
| q1_hold | output | 1 | Holds the core phase generator in its first phase |
| ost_done | output | 1 | Start-up done; system clock is from primary |
| pri_osc_en | output | 1 | Primary oscillator enable |
| tmr_osc_en | output | 1 | Timer oscillator enable |
| rc_osc_en | output | 1 | Internal RC oscillator enable |

## Verification
A sequencer stuck in its start-up state shows at the ports as `q1_hold` rising too late or not at all. The bench measures that latency against the 1024-cycle window or the 6-cycle bound for every primary mode, so a wrong count or a wrong crystal decode is caught within one return. A hold counter or ready delay of the wrong length shows as a wrong `q1_hold` width in the same return. A stale source record or a wrong shutdown rule shows one cycle after `q1_hold` falls, as a wrong oscillator enable. A multiplexer gate left open shows as `sys_clk` tracking the wrong clock within a few cycles of the slowest source.

// File: rtl/clk_return_pkg.sv
package clk_return_pkg;

    typedef enum logic [2:0] {
        ST_HAND,
        ST_HOLD,
        ST_READY,
        ST_PRI,
        ST_SEC,
        ST_OST
    } ctl_state_t;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_TMR = 2'd1,
        SRC_RC  = 2'd2
    } clk_src_t;

    localparam int NUM_SRC = 3;

    localparam logic [2:0] MODE_LP  = 3'd0;
    localparam logic [2:0] MODE_XT  = 3'd1;
    localparam logic [2:0] MODE_HS  = 3'd2;
    localparam logic [2:0] MODE_EC  = 3'd3;
    localparam logic [2:0] MODE_ERC = 3'd4;
    localparam logic [2:0] MODE_IRC = 3'd5;

    function automatic logic mode_is_xtal(logic [2:0] m);
        return (m == MODE_LP) || (m == MODE_XT) || (m == MODE_HS);
    endfunction

    // Effective source: clearing the timer enable masks select bit 0.
    function automatic clk_src_t decode_sel(logic [1:0] sel, logic tmr_on);
        if (sel[1])
            return SRC_RC;
        else if (sel[0] && tmr_on)
            return SRC_TMR;
        else
            return SRC_PRI;
    endfunction

endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/crs_gate_chan.sv
module crs_gate_chan (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic others_on,
    output logic en,
    output logic gclk
);
    logic arm_q;
    logic en_q;

    // First stage on the rising edge of this source.
    always_ff @(posedge clk) begin
        if (rst) arm_q <= 1'b0;
        else     arm_q <= want && !others_on;
    end

    // Gate enable changes only while this clock is low.
    always_ff @(negedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= arm_q;
    end

    assign en   = en_q;
    assign gclk = clk & en_q;
endmodule

// File: rtl/crs_fsm.sv
module crs_fsm
    import clk_return_pkg::*;
#(
    parameter int OST_CYC    = 1024,
    parameter int HOLD_EDGES = 8,
    parameter int READY_CYC  = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  clk_src_t   want,
    input  logic [2:0] mode,
    input  logic       pri_on,
    input  logic       tmr_on_raw,
    input  logic       wdt_use,
    input  logic       fs_use,
    output clk_src_t   tgt,
    output logic       q1_hold,
    output logic       ost_done,
    output logic       pri_osc_en,
    output logic       tmr_osc_en,
    output logic       rc_osc_en
);
    localparam int MAX_AB  = (OST_CYC > HOLD_EDGES) ? OST_CYC : HOLD_EDGES;
    localparam int CNT_MAX = (MAX_AB > READY_CYC) ? MAX_AB : READY_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    ctl_state_t    state;
    clk_src_t      src_q;
    logic [CW-1:0] cnt;
    logic          ost_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HAND;
            src_q <= SRC_PRI;
            cnt   <= '0;
            ost_q <= 1'b0;
        end else begin
            case (state)
                ST_PRI: begin
                    if (want != SRC_PRI) begin
                        src_q <= want;
                        ost_q <= 1'b0;
                        state <= ST_SEC;
                    end
                end
                ST_SEC: begin
                    if (want == SRC_PRI) begin
                        cnt   <= '0;
                        state <= mode_is_xtal(mode) ? ST_OST : ST_HAND;
                    end
                end
                ST_OST: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(OST_CYC - 1)) state <= ST_HAND;
                end
                ST_HAND: begin
                    cnt <= '0;
                    if (pri_on) state <= ST_HOLD;
                end
                ST_HOLD: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(HOLD_EDGES - 1)) begin
                        cnt <= '0;
                        if (mode_is_xtal(mode)) begin
                            state <= ST_PRI;
                            ost_q <= 1'b1;
                        end else begin
                            state <= ST_READY;
                        end
                    end
                end
                ST_READY: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(READY_CYC - 1)) begin
                        state <= ST_PRI;
                        ost_q <= 1'b1;
                    end
                end
                default: state <= ST_HAND;
            endcase
        end
    end

    logic on_sec;
    assign on_sec = (state == ST_SEC) || (state == ST_OST);

    assign tgt        = on_sec ? src_q : SRC_PRI;
    assign q1_hold    = (state == ST_HAND) || (state == ST_HOLD) || (state == ST_READY);
    assign ost_done   = ost_q;
    assign pri_osc_en = (state != ST_SEC);
    assign tmr_osc_en = tmr_on_raw || ((src_q == SRC_TMR) && (state != ST_PRI));
    assign rc_osc_en  = wdt_use || fs_use || (mode == MODE_IRC) || (want == SRC_RC)
                        || ((src_q == SRC_RC) && (state != ST_PRI));

    // R7
    ost_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEC) |-> !ost_done);

    // R4
    ost_on_sec_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OST) |-> !pri_on);

    // R7
    ost_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ost_done) |-> $fell(q1_hold));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OST) |=> ((state == ST_OST) || (state == ST_HAND)));
endmodule

// File: rtl/clk_return_ctrl.sv
module clk_return_ctrl
    import clk_return_pkg::*;
#(
    parameter int OST_CYC    = 1024,
    parameter int HOLD_EDGES = 8,
    parameter int READY_CYC  = 48
) (
    input  logic       clk_pri,
    input  logic       clk_tmr,
    input  logic       clk_rc,
    input  logic       rst,
    input  logic [1:0] clk_sel,
    input  logic       tmr_osc_on,
    input  logic [2:0] pri_mode,
    input  logic       wdt_rc_use,
    input  logic       fsm_rc_use,
    output logic       sys_clk,
    output logic       q1_hold,
    output logic       ost_done,
    output logic       pri_osc_en,
    output logic       tmr_osc_en,
    output logic       rc_osc_en
);
    logic [2:0]         req_s;
    clk_src_t           want;
    clk_src_t           tgt;
    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] chan_en;
    logic [NUM_SRC-1:0] chan_gclk;

    crs_sync #(.W(3)) u_req_sync (
        .clk (clk_pri),
        .rst (rst),
        .d   ({tmr_osc_on, clk_sel}),
        .q   (req_s)
    );

    assign want = decode_sel(req_s[1:0], req_s[2]);

    crs_fsm #(
        .OST_CYC    (OST_CYC),
        .HOLD_EDGES (HOLD_EDGES),
        .READY_CYC  (READY_CYC)
    ) u_fsm (
        .clk        (clk_pri),
        .rst        (rst),
        .want       (want),
        .mode       (pri_mode),
        .pri_on     (chan_en[0]),
        .tmr_on_raw (tmr_osc_on),
        .wdt_use    (wdt_rc_use),
        .fs_use     (fsm_rc_use),
        .tgt        (tgt),
        .q1_hold    (q1_hold),
        .ost_done   (ost_done),
        .pri_osc_en (pri_osc_en),
        .tmr_osc_en (tmr_osc_en),
        .rc_osc_en  (rc_osc_en)
    );

    assign src_clk = {clk_rc, clk_tmr, clk_pri};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chan
        logic want_i;
        logic others_i;
        assign want_i   = (tgt == clk_src_t'(i));
        assign others_i = |(chan_en & ~(NUM_SRC'(1) << i));

        crs_gate_chan u_chan (
            .clk       (src_clk[i]),
            .rst       (rst),
            .want      (want_i),
            .others_on (others_i),
            .en        (chan_en[i]),
            .gclk      (chan_gclk[i])
        );
    end

    assign sys_clk = |chan_gclk;

    // R11
    one_gate_chk: assert property (@(posedge clk_pri) disable iff (rst)
        $onehot0(chan_en));
endmodule

// File: tb/clk_return_ctrl_bench.sv
`timescale 1ns/10ps
module clk_return_ctrl_bench;
    localparam int OST    = 1024;
    localparam int HOLD   = 8;
    localparam int READY  = 48;
    localparam int SLACK  = 40;

    logic       clk_pri = 1'b0;
    logic       clk_tmr = 1'b0;
    logic       clk_rc  = 1'b0;
    logic       rst     = 1'b1;
    logic [1:0] clk_sel = 2'b00;
    logic       tmr_osc_on = 1'b1;
    logic [2:0] pri_mode = 3'd0;
    logic       wdt_rc_use = 1'b0;
    logic       fsm_rc_use = 1'b0;
    logic       sys_clk, q1_hold, ost_done, pri_osc_en, tmr_osc_en, rc_osc_en;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5  clk_pri = ~clk_pri;
    always #19.37 clk_tmr = ~clk_tmr;
    always #7.13 clk_rc  = ~clk_rc;
    always @(posedge clk_pri) cyc <= cyc + 1;

    clk_return_ctrl #(.OST_CYC(OST), .HOLD_EDGES(HOLD), .READY_CYC(READY)) u_clk_return_ctrl (
        .clk_pri(clk_pri), .clk_tmr(clk_tmr), .clk_rc(clk_rc), .rst(rst),
        .clk_sel(clk_sel), .tmr_osc_on(tmr_osc_on), .pri_mode(pri_mode),
        .wdt_rc_use(wdt_rc_use), .fsm_rc_use(fsm_rc_use),
        .sys_clk(sys_clk), .q1_hold(q1_hold), .ost_done(ost_done),
        .pri_osc_en(pri_osc_en), .tmr_osc_en(tmr_osc_en), .rc_osc_en(rc_osc_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // src: 0 primary, 1 timer oscillator, 2 internal RC
    task automatic follows(input int src, input string req);
        for (int k = 0; k < 3; k++) begin
            if (src == 0)      @(posedge clk_pri);
            else if (src == 1) @(posedge clk_tmr);
            else               @(posedge clk_rc);
            #0.5 chk(sys_clk == 1'b1, req, sys_clk, 1);
            if (src == 0)      @(negedge clk_pri);
            else if (src == 1) @(negedge clk_tmr);
            else               @(negedge clk_rc);
            #0.5 chk(sys_clk == 1'b0, req, sys_clk, 0);
        end
    endtask

    task automatic wait_hold_rise();
        do begin @(posedge clk_pri); #1; end while (!q1_hold);
    endtask

    task automatic goto_sec(input logic [1:0] s);
        @(negedge clk_pri) clk_sel = s;
        repeat (150) @(posedge clk_pri);
        #1;
        chk(ost_done == 1'b0, "R2 status low on secondary", ost_done, 0);
        chk(pri_osc_en == 1'b0, "R2 primary off on secondary", pri_osc_en, 0);
        follows(s[1] ? 2 : 1, "R2 sys_clk on secondary");
    endtask

    // Finish a return once q1_hold has risen; check hold width and end state.
    task automatic finish_return(input int m, input int src, input bit via_en);
        int h;
        int hmin;
        h = 0;
        while (q1_hold) begin @(posedge clk_pri); #1; h++; end
        hmin = HOLD + ((m >= 3) ? READY : 0);
        chk(h >= hmin && h <= hmin + SLACK, "R6 hold width", h, hmin);
        chk(ost_done == 1'b1, "R7 status after return", ost_done, 1);
        chk(pri_osc_en == 1'b1, "R6 primary enabled", pri_osc_en, 1);
        follows(0, "R6 sys_clk on primary");
        if (src == 2)
            chk(rc_osc_en == ((m == 5) || wdt_rc_use || fsm_rc_use), "R8 rc enable rule",
                rc_osc_en, (m == 5) || wdt_rc_use || fsm_rc_use);
        chk(tmr_osc_en == !via_en, "R9 timer enable rule", tmr_osc_en, !via_en);
    endtask

    task automatic do_return(input int m, input int src, input bit via_en);
        int r0;
        int lat;
        @(negedge clk_pri);
        if (via_en) tmr_osc_on = 1'b0;   // R3 return by clearing the enable
        else        clk_sel = 2'b00;     // R3 return by select
        r0 = cyc;
        if (m <= 2) begin
            follows(src, "R4 sys_clk stays on secondary");
            chk(pri_osc_en == 1'b1, "R4 primary enabled in start-up", pri_osc_en, 1);
            if (via_en) chk(tmr_osc_en == 1'b1, "R9 timer runs during return", tmr_osc_en, 1);
        end
        wait_hold_rise();
        lat = cyc - r0;
        if (m <= 2) chk(lat >= OST && lat <= OST + 6, "R4 start-up latency", lat, OST + 3);
        else        chk(lat >= 1 && lat <= 6, "R5 start-up skipped", lat, 3);
        finish_return(m, src, via_en);
        if (via_en) begin
            @(negedge clk_pri);
            clk_sel = 2'b00;
            tmr_osc_on = 1'b1;
            repeat (4) @(posedge clk_pri);
        end
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int r0;
        int lat;
        repeat (30) @(posedge clk_tmr);
        @(negedge clk_pri) rst = 1'b0;
        // R1 reset state
        wait_hold_rise();
        while (q1_hold) begin @(posedge clk_pri); #1; end
        chk(ost_done == 1'b1, "R1 status after reset", ost_done, 1);
        chk(pri_osc_en == 1'b1, "R1 primary enabled", pri_osc_en, 1);
        chk(rc_osc_en == 1'b0, "R1 rc off", rc_osc_en, 0);
        follows(0, "R1 sys_clk on primary");

        for (int m = 0; m < 6; m++) begin
            for (int s = 1; s <= 2; s++) begin
                @(negedge clk_pri) pri_mode = 3'(m);
                goto_sec(s == 1 ? 2'b01 : 2'b10);
                do_return(m, s, (s == 1) && (m % 2 == 1));
            end
        end

        // R10: select changes during the start-up count are ignored
        @(negedge clk_pri) pri_mode = 3'd0;
        goto_sec(2'b01);
        @(negedge clk_pri) clk_sel = 2'b00;
        r0 = cyc;
        repeat (200) @(posedge clk_pri);
        @(negedge clk_pri) clk_sel = 2'b10;
        repeat (200) @(posedge clk_pri);
        @(negedge clk_pri) clk_sel = 2'b00;
        wait_hold_rise();
        lat = cyc - r0;
        chk(lat >= OST && lat <= OST + 6, "R10 start-up not restarted", lat, OST + 3);
        finish_return(0, 1, 1'b0);

        // R8: in-use flags keep the internal RC running
        for (int f = 0; f < 4; f++) begin
            @(negedge clk_pri);
            pri_mode   = 3'd3;
            wdt_rc_use = f[0];
            fsm_rc_use = f[1];
            goto_sec(2'b10);
            do_return(3, 2, 1'b0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule